// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer with Pinned Entries

This block is a small, fully associative translation cache. It maps a virtual page number and the identifier of the running address space to a physical frame number. A lookup is compared against every entry in the same cycle. The hit, miss and frame outputs are registered one cycle later.

Entries from several address spaces can be resident at once. A context switch therefore only needs the current identifier to change, and no flush. Entries can be pinned, which keeps them out of replacement and out of the ordinary flushes. A configuration input can turn off identifier tagging. In that mode the identifier is ignored in matching, and a full flush clears every entry so that no stale translation survives a context switch.

On a miss the block only reports the miss. An external agent walks the page table and writes the translation through the fill port. Two counters, one for lookups that hit and one for lookups that miss, give the hit ratio.

Top module: `asid_tlb`

## Requirements
- R1: After reset every entry is invalid, both counters read zero, `hit_o`, `miss_o` and `fill_err_o` are low, and `pfn_o` is zero.
- R2: With tagging on (`asid_en_i`=1), a lookup hits only when a valid entry has an equal page number and its stored identifier equals `cur_asid_i`. `hit_o` and the frame on `pfn_o` appear on the cycle after the request. On a miss or an idle cycle `pfn_o` is zero. If several entries match, the lowest index wins.
- R3: A page number match with a different identifier is reported on `miss_o` like any other miss. Entries with the same page number and different identifiers coexist, and each returns its own frame.
- R4: With tagging off, matching ignores the identifier. A full flush (`flush_all_i`) then invalidates every entry, pinned ones included.
- R5: A fill whose page number and identifier match a valid entry (under the current tagging mode) overwrites that entry. Otherwise the fill takes the first invalid entry found by a circular scan that starts at the round-robin pointer. If there is no invalid entry, it takes the first unpinned entry in that scan. After a fill that did not overwrite, the pointer moves to the index after the chosen entry. The pointer is 0 after reset.
- R6: If a fill matches no entry and every entry is pinned, the fill is dropped, the contents stay unchanged, and `fill_err_o` is high for one cycle on the cycle after the fill.
- R7: With tagging on, a full flush invalidates only unpinned entries. The identifier flush (`flush_asid_i`) invalidates unpinned entries whose stored identifier equals `flush_asid_id_i`, in either tagging mode. A pinned entry is never evicted.
- R8: `unwire_i` invalidates the entry at `unwire_idx_i` and clears its pin, whatever its state.
- R9: Each lookup request increments exactly one of `hit_cnt_o` and `miss_cnt_o`, on the same cycle that `hit_o` or `miss_o` is raised.
- R10: A lookup is resolved against the contents held before the clock edge, so a fill or flush in the same cycle affects only later lookups. When they share a cycle, the unpin, the full flush and the identifier flush are applied first and the fill last. The fill's target is chosen from the contents held before the edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| asid_en_i | input | 1 | Identifier tagging enable |
| cur_asid_i | input | ASID_W | Identifier of the running address space |
| lkp_valid_i | input | 1 | Lookup request |
| lkp_vpn_i | input | VPN_W | Page number to translate |
| fill_valid_i | input | 1 | Fill request |
| fill_vpn_i | input | VPN_W | Fill page number |
| fill_asid_i | input | ASID_W | Fill identifier |
| fill_pfn_i | input | PFN_W | Fill frame number |
| fill_wired_i | input | 1 | Pin the filled entry |
| flush_all_i | input | 1 | Full flush |
| flush_asid_i | input | 1 | Flush by identifier |
| flush_asid_id_i | input | ASID_W | Identifier to flush |
| unwire_i | input | 1 | Unpin and invalidate one entry |
| unwire_idx_i | input | $clog2(ENTRIES) | Entry index for the unpin command |
| hit_o | output | 1 | Registered hit |
| miss_o | output | 1 | Registered miss |
| pfn_o | output | PFN_W | Registered frame on a hit, zero otherwise |
| fill_err_o | output | 1 | Fill dropped because every entry is pinned |
| hit_cnt_o | output | CNT_W | Lookups that hit |
| miss_cnt_o | output | CNT_W | Lookups that missed |

## Verification
A lookup can land in the same cycle as a fill, a flush or an unpin of the very page it asks for. The order rule of R10 decides whether that lookup hits, and whether the filled entry survives a flush in the same cycle. The bench provokes this with directed cycles that put a lookup and a fill of the same key together, and a flush and a fill together. It also runs a long random phase over a small key space, where all commands overlap freely. A behavioural model with pre-edge lookup semantics and a fixed command order produces the expected outputs, which are compared every cycle.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;
  typedef enum logic [1:0] {
    TGT_NONE  = 2'd0,
    TGT_MATCH = 2'd1,
    TGT_FREE  = 2'd2,
    TGT_EVICT = 2'd3
  } tgt_src_e;
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int ASID_W  = 8,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0]             valid_i,
  input  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_i,
  input  logic [ENTRIES-1:0][ASID_W-1:0] asid_i,
  input  logic [VPN_W-1:0]               key_vpn_i,
  input  logic [ASID_W-1:0]              key_asid_i,
  input  logic                           tag_en_i,
  output logic                           hit_o,
  output logic [IDX_W-1:0]               idx_o
);
  logic [ENTRIES-1:0] eq;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign eq[g] = valid_i[g] && (vpn_i[g] == key_vpn_i) &&
                   (!tag_en_i || (asid_i[g] == key_asid_i));
  end

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      if (eq[k]) idx_o = IDX_W'(k);
    end
  end

  assign hit_o = |eq;
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int ENTRIES = 16,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic [ENTRIES-1:0] valid_i,
  input  logic [ENTRIES-1:0] wired_i,
  input  logic [IDX_W-1:0]   ptr_i,
  output logic               free_ok_o,
  output logic [IDX_W-1:0]   free_idx_o,
  output logic               evict_ok_o,
  output logic [IDX_W-1:0]   evict_idx_o
);
  // circular scan from ptr_i; ENTRIES must be a power of two
  always_comb begin
    free_ok_o   = 1'b0;
    free_idx_o  = '0;
    evict_ok_o  = 1'b0;
    evict_idx_o = '0;
    for (int k = ENTRIES - 1; k >= 0; k--) begin
      logic [IDX_W-1:0] j;
      j = ptr_i + IDX_W'(k);
      if (!valid_i[j]) begin
        free_ok_o  = 1'b1;
        free_idx_o = j;
      end
      if (!wired_i[j]) begin
        evict_ok_o  = 1'b1;
        evict_idx_o = j;
      end
    end
  end
endmodule

// File: rtl/tlb_stats.sv
module tlb_stats #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lkp_i,
  input  logic             hit_i,
  output logic [CNT_W-1:0] hit_cnt_o,
  output logic [CNT_W-1:0] miss_cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_cnt_o  <= '0;
      miss_cnt_o <= '0;
    end else if (lkp_i) begin
      if (hit_i) hit_cnt_o  <= hit_cnt_o + CNT_W'(1);
      else       miss_cnt_o <= miss_cnt_o + CNT_W'(1);
    end
  end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
  import asid_tlb_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int VPN_W   = 20,
  parameter int PFN_W   = 20,
  parameter int ASID_W  = 8,
  parameter int CNT_W   = 32,
  localparam int IDX_W  = $clog2(ENTRIES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              asid_en_i,
  input  logic [ASID_W-1:0] cur_asid_i,
  input  logic              lkp_valid_i,
  input  logic [VPN_W-1:0]  lkp_vpn_i,
  input  logic              fill_valid_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [ASID_W-1:0] fill_asid_i,
  input  logic [PFN_W-1:0]  fill_pfn_i,
  input  logic              fill_wired_i,
  input  logic              flush_all_i,
  input  logic              flush_asid_i,
  input  logic [ASID_W-1:0] flush_asid_id_i,
  input  logic              unwire_i,
  input  logic [IDX_W-1:0]  unwire_idx_i,
  output logic              hit_o,
  output logic              miss_o,
  output logic [PFN_W-1:0]  pfn_o,
  output logic              fill_err_o,
  output logic [CNT_W-1:0]  hit_cnt_o,
  output logic [CNT_W-1:0]  miss_cnt_o
);
  logic [ENTRIES-1:0]             v_q, v_d, w_q, w_d;
  logic [ENTRIES-1:0][VPN_W-1:0]  vpn_q;
  logic [ENTRIES-1:0][ASID_W-1:0] asid_q;
  logic [ENTRIES-1:0][PFN_W-1:0]  pfn_q;
  logic [IDX_W-1:0]               ptr_q;

  logic             lkp_hit, fill_hit, free_ok, evict_ok, fill_go;
  logic [IDX_W-1:0] lkp_idx, fill_idx, free_idx, evict_idx, tgt;
  tgt_src_e         src;

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_lkp_match (
    .valid_i(v_q), .vpn_i(vpn_q), .asid_i(asid_q),
    .key_vpn_i(lkp_vpn_i), .key_asid_i(cur_asid_i), .tag_en_i(asid_en_i),
    .hit_o(lkp_hit), .idx_o(lkp_idx)
  );

  tlb_match #(.ENTRIES(ENTRIES), .VPN_W(VPN_W), .ASID_W(ASID_W)) u_fill_match (
    .valid_i(v_q), .vpn_i(vpn_q), .asid_i(asid_q),
    .key_vpn_i(fill_vpn_i), .key_asid_i(fill_asid_i), .tag_en_i(asid_en_i),
    .hit_o(fill_hit), .idx_o(fill_idx)
  );

  tlb_victim #(.ENTRIES(ENTRIES)) u_victim (
    .valid_i(v_q), .wired_i(w_q), .ptr_i(ptr_q),
    .free_ok_o(free_ok), .free_idx_o(free_idx),
    .evict_ok_o(evict_ok), .evict_idx_o(evict_idx)
  );

  tlb_stats #(.CNT_W(CNT_W)) u_stats (
    .clk_i(clk_i), .rst_ni(rst_ni), .lkp_i(lkp_valid_i), .hit_i(lkp_hit),
    .hit_cnt_o(hit_cnt_o), .miss_cnt_o(miss_cnt_o)
  );

  always_comb begin
    if (fill_hit)      src = TGT_MATCH;
    else if (free_ok)  src = TGT_FREE;
    else if (evict_ok) src = TGT_EVICT;
    else               src = TGT_NONE;
    unique case (src)
      TGT_MATCH: tgt = fill_idx;
      TGT_FREE:  tgt = free_idx;
      TGT_EVICT: tgt = evict_idx;
      default:   tgt = '0;
    endcase
    fill_go = fill_valid_i && (src != TGT_NONE);
  end

  // order: unwire, flushes, then fill
  always_comb begin
    v_d = v_q;
    w_d = w_q;
    if (unwire_i) begin
      v_d[unwire_idx_i] = 1'b0;
      w_d[unwire_idx_i] = 1'b0;
    end
    for (int i = 0; i < ENTRIES; i++) begin
      if (flush_all_i && (!asid_en_i || !w_q[i])) begin
        v_d[i] = 1'b0;
        w_d[i] = 1'b0;
      end
      if (flush_asid_i && !w_q[i] && (asid_q[i] == flush_asid_id_i)) v_d[i] = 1'b0;
    end
    if (fill_go) begin
      v_d[tgt] = 1'b1;
      w_d[tgt] = fill_wired_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      v_q   <= '0;
      w_q   <= '0;
      ptr_q <= '0;
    end else begin
      v_q <= v_d;
      w_q <= w_d;
      if (fill_go && (src != TGT_MATCH)) ptr_q <= tgt + IDX_W'(1);
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_go) begin
      vpn_q[tgt]  <= fill_vpn_i;
      asid_q[tgt] <= fill_asid_i;
      pfn_q[tgt]  <= fill_pfn_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hit_o      <= 1'b0;
      miss_o     <= 1'b0;
      pfn_o      <= '0;
      fill_err_o <= 1'b0;
    end else begin
      hit_o      <= lkp_valid_i && lkp_hit;
      miss_o     <= lkp_valid_i && !lkp_hit;
      pfn_o      <= (lkp_valid_i && lkp_hit) ? pfn_q[lkp_idx] : '0;
      fill_err_o <= fill_valid_i && !fill_go;
    end
  end

  AST_HIT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o)); // R2

  AST_HIT_COUNTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (hit_cnt_o == $past(hit_cnt_o) + CNT_W'(1))); // R9

  AST_MISS_COUNTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    miss_o |-> (miss_cnt_o == $past(miss_cnt_o) + CNT_W'(1))); // R9

  AST_VICTIM_UNPINNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_go && !fill_hit) |-> !w_q[tgt]); // R5

  AST_ALL_PINNED_REJECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_valid_i && (&w_q) && !fill_hit) |=> fill_err_o); // R6

  AST_TAGOFF_FLUSH_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_all_i && !asid_en_i && !fill_valid_i) |=> (v_q == '0)); // R4

  AST_UNWIRE_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (unwire_i && !fill_valid_i) |=> !v_q[$past(unwire_idx_i)] && !w_q[$past(unwire_idx_i)]); // R8

  for (genvar g = 0; g < ENTRIES; g++) begin : g_pin_chk
    AST_PINNED_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (asid_en_i && w_q[g] && !(unwire_i && (unwire_idx_i == IDX_W'(g)))) |=> v_q[g]); // R7
  end
endmodule

// File: tb/tb_asid_tlb.sv
module tb_asid_tlb;
  localparam int N = 16;
  localparam int VW = 20, PW = 20, AW = 8, CW = 32, IW = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic asid_en = 1'b1;
  logic [AW-1:0] cur_asid = '0;
  logic lkp_v = 1'b0; logic [VW-1:0] lkp_vpn = '0;
  logic fill_v = 1'b0; logic [VW-1:0] fill_vpn = '0; logic [AW-1:0] fill_asid = '0;
  logic [PW-1:0] fill_pfn = '0; logic fill_w = 1'b0;
  logic fl_all = 1'b0, fl_asid = 1'b0; logic [AW-1:0] fl_id = '0;
  logic unw = 1'b0; logic [IW-1:0] unw_idx = '0;
  logic hit, miss, ferr; logic [PW-1:0] pfn; logic [CW-1:0] hcnt, mcnt;

  always #5 clk = ~clk;

  asid_tlb dut (
    .clk_i(clk), .rst_ni(rst_n), .asid_en_i(asid_en), .cur_asid_i(cur_asid),
    .lkp_valid_i(lkp_v), .lkp_vpn_i(lkp_vpn),
    .fill_valid_i(fill_v), .fill_vpn_i(fill_vpn), .fill_asid_i(fill_asid),
    .fill_pfn_i(fill_pfn), .fill_wired_i(fill_w),
    .flush_all_i(fl_all), .flush_asid_i(fl_asid), .flush_asid_id_i(fl_id),
    .unwire_i(unw), .unwire_idx_i(unw_idx),
    .hit_o(hit), .miss_o(miss), .pfn_o(pfn), .fill_err_o(ferr),
    .hit_cnt_o(hcnt), .miss_cnt_o(mcnt)
  );

  // behavioural reference
  bit m_v[N], m_w[N];
  int m_vpn[N], m_asid[N], m_pfn[N];
  int m_ptr;
  bit e_hit, e_miss, e_err; int e_pfn, e_hc, e_mc;
  int checks = 0, fails = 0;
  string req = "R1";
  bit done = 0;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      foreach (m_v[i]) begin m_v[i] = 0; m_w[i] = 0; end
      m_ptr = 0; e_hit = 0; e_miss = 0; e_err = 0; e_pfn = 0; e_hc = 0; e_mc = 0;
    end else begin
      int li, ti; bit nv[N], nw[N];
      li = -1;
      for (int i = 0; i < N; i++)
        if (li < 0 && m_v[i] && m_vpn[i] == int'(lkp_vpn) && (!asid_en || m_asid[i] == int'(cur_asid))) li = i;
      e_hit = lkp_v && li >= 0; e_miss = lkp_v && li < 0;
      e_pfn = e_hit ? m_pfn[li] : 0;
      if (e_hit) e_hc++; if (e_miss) e_mc++;
      ti = -1;
      for (int i = 0; i < N; i++)
        if (ti < 0 && m_v[i] && m_vpn[i] == int'(fill_vpn) && (!asid_en || m_asid[i] == int'(fill_asid))) ti = i;
      if (ti >= 0) begin
        ;
      end else begin
        for (int k = 0; k < N; k++) if (ti < 0 && !m_v[(m_ptr + k) % N]) ti = (m_ptr + k) % N;
        for (int k = 0; k < N; k++) if (ti < 0 && !m_w[(m_ptr + k) % N]) ti = (m_ptr + k) % N;
        if (fill_v && ti >= 0) m_ptr = (ti + 1) % N;
      end
      e_err = fill_v && ti < 0;
      foreach (nv[i]) begin nv[i] = m_v[i]; nw[i] = m_w[i]; end
      if (unw) begin nv[unw_idx] = 0; nw[unw_idx] = 0; end
      for (int i = 0; i < N; i++) begin
        if (fl_all && (!asid_en || !m_w[i])) begin nv[i] = 0; nw[i] = 0; end
        if (fl_asid && !m_w[i] && m_asid[i] == int'(fl_id)) nv[i] = 0;
      end
      if (fill_v && ti >= 0) begin
        nv[ti] = 1; nw[ti] = fill_w;
        m_vpn[ti] = int'(fill_vpn); m_asid[ti] = int'(fill_asid); m_pfn[ti] = int'(fill_pfn);
      end
      foreach (nv[i]) begin m_v[i] = nv[i]; m_w[i] = nw[i]; end
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (hit !== e_hit || miss !== e_miss || int'(pfn) != e_pfn || ferr !== e_err ||
          int'(hcnt) != e_hc || int'(mcnt) != e_mc) begin
        fails++;
        $display("FAIL %s hit=%b/%b miss=%b/%b pfn=%h/%h err=%b/%b hc=%0d/%0d mc=%0d/%0d (actual/expected)",
                 req, hit, e_hit, miss, e_miss, pfn, e_pfn, ferr, e_err, hcnt, e_hc, mcnt, e_mc);
      end
    end
  end

  task automatic idle();
    lkp_v = 0; fill_v = 0; fl_all = 0; fl_asid = 0; unw = 0; fill_w = 0;
  endtask
  task automatic step(); @(negedge clk); idle(); endtask
  task automatic lookup(input int vpn, input int asid);
    lkp_v = 1; lkp_vpn = VW'(vpn); cur_asid = AW'(asid); step();
  endtask
  task automatic fill(input int vpn, input int asid, input int pf, input bit w);
    fill_v = 1; fill_vpn = VW'(vpn); fill_asid = AW'(asid); fill_pfn = PW'(pf); fill_w = w; step();
  endtask

  initial begin
    int wd = 0;
    forever begin
      @(posedge clk); wd++;
      if (wd > 100000 && !done) begin
        fails++; checks++;
        $display("FAIL watchdog expired in %s", req);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    checks++;
    if (hit !== 0 || miss !== 0 || pfn !== 0 || ferr !== 0 || hcnt !== 0 || mcnt !== 0) begin
      fails++; $display("FAIL R1 outputs after reset actual=%b%b%h%b expected=0", hit, miss, pfn, ferr);
    end
    rst_n = 1; step();
    lookup(5, 0); step();
    // R2 / R3
    req = "R2"; fill('h10, 1, 'h100, 0); lookup('h10, 1); lookup('h11, 1); step();
    req = "R3"; lookup('h10, 2); fill('h10, 2, 'h200, 0); lookup('h10, 2); lookup('h10, 1); step();
    // R5: overwrite, fill to capacity, then round-robin eviction
    req = "R5"; fill('h10, 1, 'h111, 0); lookup('h10, 1);
    for (int i = 0; i < 20; i++) fill('h40 + i, 3, 'h400 + i, 0);
    for (int i = 0; i < 20; i++) lookup('h40 + i, 3);
    // R7: pinned survive flushes
    req = "R7"; fill('h80, 4, 'h800, 1); fill('h81, 5, 'h810, 1); fill('h82, 5, 'h820, 0);
    fl_asid = 1; fl_id = 5; step(); lookup('h81, 5); lookup('h82, 5);
    fl_all = 1; step(); lookup('h80, 4); lookup('h40 + 19, 3);
    // R8: unpin by index
    req = "R8"; for (int i = 0; i < N; i++) begin unw = 1; unw_idx = IW'(i); step(); lookup('h80, 4); end
    // R6: all pinned rejects
    req = "R6"; for (int i = 0; i < N; i++) fill('hA0 + i, 6, 'hA00 + i, 1);
    fill('hF0, 6, 'hF00, 0); lookup('hF0, 6); fill('hA3, 6, 'hBBB, 1); lookup('hA3, 6);
    // R4: tagging off
    req = "R4"; asid_en = 0; lookup('hA5, 9); fl_all = 1; step(); lookup('hA5, 6);
    fill('h20, 1, 'h222, 0); lookup('h20, 7); fill('h20, 3, 'h333, 0); lookup('h20, 1);
    fl_asid = 1; fl_id = 3; step(); lookup('h20, 3); asid_en = 1;
    // R10: same-cycle interactions
    req = "R10"; lkp_v = 1; lkp_vpn = 'h30; cur_asid = 2; fill_v = 1; fill_vpn = 'h30;
    fill_asid = 2; fill_pfn = 'h303; step(); lookup('h30, 2);
    fl_all = 1; fill_v = 1; fill_vpn = 'h31; fill_asid = 2; fill_pfn = 'h313; lkp_v = 1; lkp_vpn = 'h30; step();
    lookup('h31, 2); lookup('h30, 2);
    lkp_v = 1; lkp_vpn = 'h31; unw = 1; unw_idx = 0; fl_asid = 1; fl_id = 2; step(); lookup('h31, 2);
    // R9 and mixed traffic
    req = "R9";
    for (int c = 0; c < 3000; c++) begin
      lkp_v = 1'($urandom); lkp_vpn = VW'($urandom_range(0, 7)); cur_asid = AW'($urandom_range(0, 3));
      fill_v = ($urandom_range(0, 2) == 0); fill_vpn = VW'($urandom_range(0, 7));
      fill_asid = AW'($urandom_range(0, 3)); fill_pfn = PW'($urandom); fill_w = ($urandom_range(0, 5) == 0);
      fl_all = ($urandom_range(0, 40) == 0); fl_asid = ($urandom_range(0, 25) == 0);
      fl_id = AW'($urandom_range(0, 3)); unw = ($urandom_range(0, 8) == 0); unw_idx = IW'($urandom);
      asid_en = ($urandom_range(0, 9) != 0);
      step();
    end
    asid_en = 1; step(); step();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule